// File: doc/BRIEF.md
# Two-Wire Open-Drain Serial Shifter

This block moves one byte at a time over a two-wire bus. The bus has a shared open-drain data line and a clock line. The block is the clock source. It pulls the clock line low for the first half of each bit and releases it for the second half. It also pulls the data line low whenever the bit it is sending is 0. Sending and receiving happen in the same transfer. On each rising edge of the clock line, the shift register moves left by one place and takes in the level seen on the data line. After eight bits the register therefore holds the wired-AND of what this block sent and what any other device on the bus drove.

Software starts a transfer by writing a byte to the data register, but only when the channel is enabled and the bus clock is idle. To receive, software writes all ones, which leaves the data line free for the other device to drive. To detect a transmit error, software can compare the shift register after the transfer with the byte it wrote. It can also write the same byte to the address register and read the match flag, which is updated at the end of every transfer. An interrupt flag is set when the eighth bit completes and stays set until software clears it.

The state machine has three states. `ST_IDLE` holds both lines released. `ST_LOW` pulls the clock line low and presents the current bit. `ST_HIGH` releases the clock line. The transitions are:

- **start**: IDLE to LOW, on a valid data write.
- **rise**: LOW to HIGH, on a clock-enable tick; the bus is sampled on this transition.
- **next**: HIGH to LOW, on a tick while bits remain.
- **finish**: HIGH to IDLE, on a tick after the eighth bit.
- **abort**: any state to IDLE, when the enable bit is cleared.

Top module: `twire_shifter`

## Requirements
- R1: A write to the data register (select 0) moves the block to busy on the next clock edge, but only when the enable bit (control register select 2, bit 0) is 1, the block is idle and `scl_in` is high.
- R2: A data write made while the enable bit is 0 loads the shift register but starts no transfer. Setting the enable bit afterwards does not start one either.
- R3: A data write made while `scl_in` is low starts no transfer.
- R4: Every transfer makes exactly 8 clock pulses. `busy` falls and `irq` rises on the same edge, just after the eighth pulse.
- R5: Bits go out MSB first. During a transfer `sda_pull` is high exactly when the current bit is 0. While idle, `sda_pull` and `scl_pull` are both low.
- R6: After a transfer the shift register holds the data-line levels sampled at each rising clock pulse, in order, MSB first. This is the bitwise AND of the sent byte and the byte driven by the other device.
- R7: At the end of each transfer, `match` is set to 1 if the full shift register equals the address register (select 1), and to 0 otherwise.
- R8: Data writes made while `busy` is high are ignored.
- R9: `irq` stays high until a write to the status register (select 3). If that write falls in the same cycle as the end of a transfer, the setting wins.
- R10: A control write with bit 0 equal to 0 during a transfer makes `busy`, `sda_pull` and `scl_pull` low on the next edge, and sets no `irq`.
- R11: After reset, `busy`, `irq`, `match`, `sda_pull`, `scl_pull` and `shift_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 address, 2 control, 3 status clear |
| reg_wdata | input | 8 | Write data |
| tick | input | 1 | Internal clock enable; each pulse advances half a bit |
| sda_in | input | 1 | Level seen on the data line |
| scl_in | input | 1 | Level seen on the clock line |
| sda_pull | output | 1 | Pull the data line low when 1 |
| scl_pull | output | 1 | Pull the clock line low when 1 |
| shift_data | output | 8 | Shift register contents |
| ctrl_en | output | 1 | Enable bit |
| busy | output | 1 | Transfer in progress |
| match | output | 1 | Address comparator result from the last transfer |
| irq | output | 1 | Transfer-complete interrupt flag |

## Verification
A wrong bit count shows within one transfer: the number of clock pulses differs from eight, and `irq` rises early or late. A stuck output bit or a wrong shift order shows in the data-line pattern seen at each rising clock pulse, and in `shift_data` at completion. A comparator that uses stale shift data reports the wrong `match` on the first transfer whose received byte differs from the one before it. A lost enable or abort path shows on the very next edge, as a `busy` that does not change.

// File: rtl/tws_pkg.sv
package tws_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } bit_state_e;
endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl #(
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic scl_pull,
    output logic sample,
    output logic reload,
    output logic done
);
    import tws_pkg::*;

    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    bit_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic            last_bit;

    assign last_bit = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick)  state_d = last_bit ? ST_IDLE : ST_LOW;
            default:            state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        scl_pull = (state_q == ST_LOW);
        sample   = (state_q == ST_LOW)  && tick && !abort;
        reload   = (state_q == ST_HIGH) && tick && !last_bit && !abort;
        done     = (state_q == ST_HIGH) && tick &&  last_bit && !abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (start)  cnt_q <= '0;
        else if (reload) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tws_shreg.sv
module tws_shreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          sample,
    input  logic          line_bit,
    input  logic          reload,
    output logic [DW-1:0] data,
    output logic          out_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data    <= '0;
            out_bit <= 1'b1;
        end else if (load) begin
            data    <= load_data;
            out_bit <= load_data[DW-1];
        end else begin
            if (sample) data    <= {data[DW-2:0], line_bit};
            if (reload) out_bit <= data[DW-1];
        end
    end
endmodule

// File: rtl/tws_cmp.sv
module tws_cmp #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_wr,
    input  logic [DW-1:0] addr_d,
    input  logic          eval,
    input  logic [DW-1:0] cur,
    output logic          match
);
    logic [DW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            match  <= 1'b0;
        end else begin
            if (addr_wr) addr_q <= addr_d;
            if (eval)    match  <= (cur == addr_q);
        end
    end
endmodule

// File: rtl/twire_shifter.sv
module twire_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          tick,
    input  logic          sda_in,
    input  logic          scl_in,
    output logic          sda_pull,
    output logic          scl_pull,
    output logic [DW-1:0] shift_data,
    output logic          ctrl_en,
    output logic          busy,
    output logic          match,
    output logic          irq
);
    import tws_pkg::*;

    logic data_wr, addr_wr, ctrl_wr, stat_wr;
    logic start, load, abort;
    logic sample, reload, done, out_bit;

    assign data_wr = reg_wr && (reg_sel == SEL_DATA);
    assign addr_wr = reg_wr && (reg_sel == SEL_ADDR);
    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
    assign stat_wr = reg_wr && (reg_sel == SEL_STAT);

    assign abort = !ctrl_en || (ctrl_wr && !reg_wdata[0]);
    assign load  = data_wr && !busy;
    assign start = load && ctrl_en && scl_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (ctrl_wr)      ctrl_en <= reg_wdata[0];
            if (done)         irq     <= 1'b1;
            else if (stat_wr) irq     <= 1'b0;
        end
    end

    tws_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .abort(abort),
        .busy(busy), .scl_pull(scl_pull), .sample(sample), .reload(reload), .done(done)
    );

    tws_shreg #(.DW(DW)) u_shreg (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(reg_wdata),
        .sample(sample), .line_bit(sda_in), .reload(reload),
        .data(shift_data), .out_bit(out_bit)
    );

    tws_cmp #(.DW(DW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_d(reg_wdata),
        .eval(done), .cur(shift_data), .match(match)
    );

    assign sda_pull = busy && !out_bit;
endmodule

// File: rtl/tws_chk.sv
module tws_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic       wdata0,
    input logic       scl_in,
    input logic       ctrl_en,
    input logic       busy,
    input logic       irq,
    input logic       sda_pull,
    input logic       scl_pull
);
    // R1
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && ctrl_en && !busy && scl_in) |=> busy);

    // R3
    scl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && !busy && !scl_in) |=> !busy);

    // R4
    irq_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && ctrl_en) |-> irq);

    // R5
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sda_pull && !scl_pull));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_sel == 2'd3)) |=> irq);

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2 && !wdata0) |=> (!busy && !sda_pull && !scl_pull));
endmodule

bind twire_shifter tws_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wdata0(reg_wdata[0]), .scl_in(scl_in), .ctrl_en(ctrl_en), .busy(busy),
    .irq(irq), .sda_pull(sda_pull), .scl_pull(scl_pull)
);

// File: tb/tb_twire_shifter.sv
module tb_twire_shifter;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] result;
        logic       mtch;
        logic [7:0] sent;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       tick = 1'b0;
    logic       sda_in, scl_in;
    logic       sda_pull, scl_pull, ctrl_en, busy, match, irq;
    logic [7:0] shift_data;

    logic [7:0] slv_byte = 8'hFF;
    logic       scl_hold = 1'b0;
    logic [3:0] edge_cnt = 4'd0;
    logic       scl_prev = 1'b0;
    logic [7:0] tx_obs = 8'd0;
    logic       slave_pull;
    logic       irq_d = 1'b0;
    logic       finished = 1'b0;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    twire_shifter dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .tick(tick), .sda_in(sda_in), .scl_in(scl_in),
        .sda_pull(sda_pull), .scl_pull(scl_pull), .shift_data(shift_data),
        .ctrl_en(ctrl_en), .busy(busy), .match(match), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign slave_pull = busy && (edge_cnt < 4'd8) && !slv_byte[3'(4'd7 - edge_cnt)];
    assign sda_in = !(sda_pull || slave_pull);
    assign scl_in = !(scl_pull || scl_hold);

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        scl_prev <= scl_pull;
        if (!busy) edge_cnt <= 4'd0;
        else if (scl_prev && !scl_pull) begin
            if (edge_cnt < 4'd8) tx_obs[3'(4'd7 - edge_cnt)] <= !sda_pull;
            edge_cnt <= edge_cnt + 4'd1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // monitor: pops the expected item when irq rises
    always @(negedge clk) begin
        if (rst_n && irq && !irq_d) begin
            if (sb_q.size() == 0) chk(1'b0, "R4 unexpected irq", 32'(irq), 32'd0);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(shift_data == e.result, "R6 received byte", 32'(shift_data), 32'(e.result));
                chk(match == e.mtch, "R7 match flag", 32'(match), 32'(e.mtch));
                chk(edge_cnt == 4'd8 && !busy, "R4 pulse count", 32'(edge_cnt), 32'd8);
                chk(tx_obs == e.sent, "R5 msb-first pattern", 32'(tx_obs), 32'(e.sent));
            end
        end
        irq_d = irq;
    end

    task automatic xfer(input logic [7:0] tx, input logic [7:0] slv,
                        input logic [7:0] adr, input bit mid_write);
        exp_t e;
        slv_byte = slv;
        wr(2'd1, adr);
        e.result = tx & slv;
        e.mtch   = ((tx & slv) == adr);
        e.sent   = tx;
        sb_q.push_back(e);
        wr(2'd0, tx);
        chk(busy == 1'b1, "R1 busy after write", 32'(busy), 32'd1);
        if (mid_write) begin
            repeat (20) @(negedge clk);
            wr(2'd0, ~tx); // R8: ignored while busy
        end
        while (!irq) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(irq == 1'b1, "R9 irq held", 32'(irq), 32'd1);
        chk(!sda_pull && !scl_pull, "R5 lines released", 32'({sda_pull, scl_pull}), 32'd0);
        if (mid_write) chk(shift_data == (tx & slv), "R8 write ignored", 32'(shift_data), 32'(tx & slv));
        wr(2'd3, 8'd0);
        chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11
        chk(!busy && !irq && !match && !sda_pull && !scl_pull && shift_data == 8'd0,
            "R11 reset state", 32'({busy, irq, match, sda_pull, scl_pull, shift_data}), 32'd0);

        wr(2'd2, 8'd1);
        xfer(8'hA5, 8'hFF, 8'hA5, 1'b0);
        xfer(8'h3C, 8'hF0, 8'h3C, 1'b0);
        xfer(8'hFF, 8'h5A, 8'h00, 1'b0);
        xfer(8'h81, 8'hFF, 8'h81, 1'b1);
        xfer(8'h00, 8'hFF, 8'h00, 1'b0);
        xfer(8'hFF, 8'hC3, 8'hC3, 1'b0);

        // R3: clock line held low blocks the start
        scl_hold = 1'b1;
        wr(2'd0, 8'h12);
        chk(busy == 1'b0, "R3 no start on low clock", 32'(busy), 32'd0);
        scl_hold = 1'b0;
        repeat (20) @(negedge clk);
        chk(!busy && !irq, "R3 still idle", 32'({busy, irq}), 32'd0);

        // R2: write before enable
        wr(2'd2, 8'd0);
        wr(2'd0, 8'h55);
        chk(busy == 1'b0, "R2 no start when disabled", 32'(busy), 32'd0);
        wr(2'd2, 8'd1);
        repeat (40) @(negedge clk);
        chk(!busy && !irq, "R2 enable later starts nothing", 32'({busy, irq}), 32'd0);
        chk(shift_data == 8'h55, "R2 data loaded", 32'(shift_data), 32'h55);

        // R10: abort mid-transfer
        slv_byte = 8'hFF;
        wr(2'd0, 8'h0F);
        chk(busy == 1'b1, "R1 busy before abort", 32'(busy), 32'd1);
        repeat (12) @(negedge clk);
        wr(2'd2, 8'd0);
        chk(!busy && !sda_pull && !scl_pull, "R10 abort releases",
            32'({busy, sda_pull, scl_pull}), 32'd0);
        repeat (40) @(negedge clk);
        chk(irq == 1'b0, "R10 no irq after abort", 32'(irq), 32'd0);
        chk(sb_q.size() == 0, "R4 all transfers completed", 32'(sb_q.size()), 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule